// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and an asynchronous byte-wide static memory of 8192 bytes. The host gives one request at a time: a strobe, a read/write select, a 13-bit address and, for writes, a data byte. The controller then drives the memory's active-low chip enable, output enable and write enable. It also drives the memory address and a split tri-state data bus made of an output value, an input value and an output enable. At the end it reports completion with a one-clock done pulse, and for reads it returns the captured byte.

Each timing limit is a nanosecond parameter. The controller turns it into a count of clocks by ceiling division by the clock-period parameter, with a floor of one clock.

A read holds chip enable and output enable low for the longest of three limits: address access, output-enable access and chip-enable access. That span is never shorter than the minimum cycle time. A write has four fixed phases: address setup, a write window in which chip enable and write enable are low together, a data hold phase, and a recovery phase that pads the whole write out to the minimum cycle time.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low and whenever the controller is idle, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and busy is 0. During and straight after reset, done is 0.
- R2: A read accepted at a clock edge pulls mem_ce_n and mem_oe_n low, with mem_we_n kept high, for exactly READ_C clocks starting with the next cycle. READ_C is the largest of the access, output-enable, chip-enable and cycle counts, which is 38 at a 4 ns period. The byte on mem_din at the edge that ends this span appears on rdata together with done in the next cycle.
- R3: A write accepted at an edge drives the address with all strobes high for SETUP_C clocks (1 by default). mem_ce_n and mem_we_n then fall together and stay low for PULSE_C clocks. PULSE_C is the larger of the pulse-width and data-setup counts, which is 25 at a 4 ns period. Both then rise in the same cycle.
- R4: mem_dq_oe is 1 from the first cycle of the write window until HOLD_C clocks after the window closes (3 by default), and is 0 otherwise. While it is 1, mem_dout equals the write byte. mem_oe_n never falls in a cycle that directly follows one with mem_dq_oe at 1.
- R5: After the hold phase, the strobes stay high for REC_C clocks before done. REC_C is the larger of the recovery count and the remainder of the cycle count, which is 9 by default. A write therefore keeps busy high for 38 clocks.
- R6: mem_oe_n is 1 in every cycle where mem_we_n is 0 or mem_dq_oe is 1.
- R7: mem_addr takes the request address in the cycle after acceptance and holds it unchanged until busy falls.
- R8: A request raised while busy is 1 is ignored. The sequence in flight, its address and the memory contents it touches are unchanged by it.
- R9: busy is 1 from the cycle after acceptance until the last cycle of the operation. done is 1 for exactly the one cycle after that, in which a new request can be accepted.
- R10: The clock counts equal the ceiling of each nanosecond limit divided by the clock period, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while idle |
| req_wr | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 13 | Byte address of the request |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 13 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_din | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
A wrong phase state or count shows up at the strobe pins in the first cycle where the state differs from the schedule. A strobe falls or rises one clock early or late, or mem_dq_oe overlaps the recovery phase, and the per-cycle reference comparison flags that cycle. A wrongly held address or a request that was not ignored shows on mem_addr in the cycle after the intruding strobe. A corrupted write stays hidden until a later read of that address returns a different byte. For that reason the sequence reads back every address it writes, including the addresses touched by ignored requests.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WREC
    } seq_state_e;

    // Ceiling of ns / period, never below one clock.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_NS   = 4,
    parameter int unsigned T_ACC_NS = 150,
    parameter int unsigned T_OE_NS  = 70,
    parameter int unsigned T_CE_NS  = 150,
    parameter int unsigned T_CYC_NS = 150,
    parameter int unsigned T_WP_NS  = 100,
    parameter int unsigned T_DS_NS  = 60,
    parameter int unsigned T_AS_NS  = 0,
    parameter int unsigned T_DH_NS  = 10,
    parameter int unsigned T_WR_NS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_cap,
    output logic              wr_fin,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dq_oe
);

    // Phase lengths in clocks (R10).
    localparam int unsigned SETUP_C = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int unsigned PULSE_C = umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
    localparam int unsigned HOLD_C  = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int unsigned CYC_C   = ns_to_cyc(T_CYC_NS, CLK_NS);
    localparam int unsigned USED_C  = SETUP_C + PULSE_C + HOLD_C;
    localparam int unsigned REC_C   = umax(ns_to_cyc(T_WR_NS, CLK_NS),
                                           (CYC_C > USED_C) ? (CYC_C - USED_C) : 0);
    localparam int unsigned READ_C  = umax(umax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                           umax(ns_to_cyc(T_CE_NS, CLK_NS), CYC_C));
    localparam int unsigned MAX_C   = umax(umax(READ_C, PULSE_C), umax(REC_C, umax(HOLD_C, SETUP_C)));
    localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      last_w;

    assign last_w = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (!last_w && r_q.st != ST_IDLE) r_d.cnt = r_q.cnt - 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (req_wr) begin
                        r_d.st  = ST_WSETUP;
                        r_d.cnt = CNT_W'(SETUP_C - 1);
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.cnt  = CNT_W'(READ_C - 1);
                        r_d.ce_n = 1'b0;
                        r_d.oe_n = 1'b0;
                    end
                end
            end
            ST_RD: begin
                if (last_w) begin
                    r_d.st   = ST_IDLE;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                end
            end
            ST_WSETUP: begin
                if (last_w) begin
                    r_d.st    = ST_WPULSE;
                    r_d.cnt   = CNT_W'(PULSE_C - 1);
                    r_d.ce_n  = 1'b0;
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                end
            end
            ST_WPULSE: begin
                if (last_w) begin
                    r_d.st   = ST_WHOLD;
                    r_d.cnt  = CNT_W'(HOLD_C - 1);
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                if (last_w) begin
                    r_d.st    = ST_WREC;
                    r_d.cnt   = CNT_W'(REC_C - 1);
                    r_d.dq_oe = 1'b0;
                end
            end
            ST_WREC: begin
                if (last_w) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign rd_cap    = (r_q.st == ST_RD) && last_w;
    assign wr_fin    = (r_q.st == ST_WREC) && last_w;
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_dout  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;

    // Length of the current write-enable low run, for the pulse-width check.
    logic [CNT_W:0] we_lo_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        we_lo_q <= '0;
        else if (!mem_we_n) we_lo_q <= we_lo_q + 1'b1;
        else               we_lo_q <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q >= (CNT_W+1)'(PULSE_C))); // R3
    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R4
    AST_OE_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mem_addr))); // R7

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cap,
    input  logic              wr_fin,
    input  logic [DATA_W-1:0] mem_din,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              done;
    } cap_regs_t;

    cap_regs_t c_q, c_d;

    always_comb begin
        c_d      = c_q;
        c_d.done = rd_cap || wr_fin;
        if (rd_cap) c_d.rdata = mem_din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rdata = c_q.rdata;
    assign done  = c_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ONE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_cap && wr_fin)); // R9

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_NS   = 4,
    parameter int unsigned T_ACC_NS = 150,
    parameter int unsigned T_OE_NS  = 70,
    parameter int unsigned T_CE_NS  = 150,
    parameter int unsigned T_CYC_NS = 150,
    parameter int unsigned T_WP_NS  = 100,
    parameter int unsigned T_DS_NS  = 60,
    parameter int unsigned T_AS_NS  = 0,
    parameter int unsigned T_DH_NS  = 10,
    parameter int unsigned T_WR_NS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe
);

    logic rd_cap_w;
    logic wr_fin_w;

    sram_cycle_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CLK_NS  (CLK_NS),
        .T_ACC_NS(T_ACC_NS),
        .T_OE_NS (T_OE_NS),
        .T_CE_NS (T_CE_NS),
        .T_CYC_NS(T_CYC_NS),
        .T_WP_NS (T_WP_NS),
        .T_DS_NS (T_DS_NS),
        .T_AS_NS (T_AS_NS),
        .T_DH_NS (T_DH_NS),
        .T_WR_NS (T_WR_NS)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .busy     (busy),
        .rd_cap   (rd_cap_w),
        .wr_fin   (wr_fin_w),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .mem_dout (mem_dout),
        .mem_dq_oe(mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) i_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_cap (rd_cap_w),
        .wr_fin (wr_fin_w),
        .mem_din(mem_din),
        .rdata  (rdata),
        .done   (done)
    );

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

    // Clock counts at 4 ns, worked out from the requirements (R10):
    // setup ceil(0/4)->1, pulse max(ceil(100/4),ceil(60/4))=25, hold ceil(10/4)=3,
    // cycle ceil(150/4)=38, recovery max(3, 38-29)=9, read max(38,18,38,38)=38.
    localparam int E_SETUP = 1;
    localparam int E_PULSE = 25;
    localparam int E_HOLD  = 3;
    localparam int E_REC   = 9;
    localparam int E_READ  = 38;
    localparam int E_WTOT  = E_SETUP + E_PULSE + E_HOLD + E_REC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [12:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    // Memory device model.
    logic [7:0] cells [int];
    function automatic logic [7:0] cell_rd(input int a);
        return cells.exists(a) ? cells[a] : init_val(a);
    endfunction
    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) cells[int'(mem_addr)] = mem_dout;
    always @(negedge clk)
        mem_din <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? cell_rd(int'(mem_addr)) : 8'h00;

    // Reference model: contents as the host expects them, plus cycle schedule.
    logic [7:0] ref_mem [int];
    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    bit         m_active = 0;
    bit         m_wr = 0;
    int         m_k = 0;
    int         m_tot = 0;
    bit         exp_done = 0;
    logic [12:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  exp_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; exp_done = 0;
        end else begin
            exp_done = 0;
            if (m_active) begin
                m_k++;
                if (m_k > m_tot) begin
                    m_active = 0;
                    exp_done = 1;
                end
            end else if (req) begin
                m_active = 1; m_k = 1; m_wr = req_wr;
                m_addr = req_addr; m_wdata = req_wdata;
                m_tot = req_wr ? E_WTOT : E_READ;
                if (req_wr) ref_mem[int'(req_addr)] = req_wdata;
                else        exp_rdata = ref_rd(int'(req_addr));
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit e_ce, e_we, e_oe, e_dq;
            e_ce = 1; e_we = 1; e_oe = 1; e_dq = 0;
            if (m_active) begin
                if (m_wr) begin
                    e_ce = !(m_k > E_SETUP && m_k <= E_SETUP + E_PULSE);
                    e_we = e_ce;
                    e_dq = (m_k > E_SETUP && m_k <= E_SETUP + E_PULSE + E_HOLD);
                end else begin
                    e_ce = 0; e_oe = 0;
                end
                chk("R7 R8 address held", int'(mem_addr), int'(m_addr));
            end
            chk("R9 R10 busy span", int'(busy), int'(m_active));
            chk("R9 done pulse", int'(done), int'(exp_done));
            chk(m_wr ? "R3 ce_n write" : "R2 ce_n read", int'(mem_ce_n), int'(e_ce));
            chk("R3 R5 we_n", int'(mem_we_n), int'(e_we));
            chk("R2 R6 oe_n", int'(mem_oe_n), int'(e_oe));
            chk("R4 dq_oe", int'(mem_dq_oe), int'(e_dq));
            if (e_dq) chk("R4 write byte", int'(mem_dout), int'(m_wdata));
            if (exp_done && !m_wr) chk("R2 read byte", int'(rdata), int'(exp_rdata));
        end
    end

    task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d, input bit noise);
        @(negedge clk);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 0;
        while (busy) begin
            if (noise) begin
                // R8: intruding requests while busy
                req = 1; req_wr = ~wr; req_addr = a ^ 13'h0F0F; req_wdata = ~d;
                @(negedge clk);
                req = 0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ce_n reset", int'(mem_ce_n), 1);
        chk("R1 we_n reset", int'(mem_we_n), 1);
        chk("R1 oe_n reset", int'(mem_oe_n), 1);
        chk("R1 dq_oe reset", int'(mem_dq_oe), 0);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 done reset", int'(done), 0);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        chk("R1 idle after reset", int'(mem_ce_n & mem_we_n & mem_oe_n), 1);

        issue(0, 13'h0000, 8'h00, 0);       // R2 lowest address
        issue(0, 13'h1FFF, 8'h00, 0);       // R2 highest address
        issue(0, 13'h1555, 8'h00, 0);
        issue(1, 13'h0000, 8'h00, 0);       // R3 all-zero byte
        issue(1, 13'h1FFF, 8'hFF, 0);       // R3 all-one byte
        issue(1, 13'h0AAA, 8'h5A, 0);
        issue(0, 13'h0000, 8'h00, 0);       // read-backs
        issue(0, 13'h1FFF, 8'h00, 0);
        issue(0, 13'h0AAA, 8'h00, 0);
        issue(1, 13'h0100, 8'hC3, 1);       // R8 ignored requests during a write
        issue(0, 13'h0100, 8'h00, 1);       // R8 ignored requests during a read
        issue(0, 13'h0100 ^ 13'h0F0F, 8'h00, 0); // untouched by ignored write
        lfsr = 13'h1ACE;
        for (int i = 0; i < 30; i++) begin
            lfsr = {lfsr[11:0], lfsr[12] ^ lfsr[3] ^ lfsr[2] ^ lfsr[0]};
            issue(lfsr[0], lfsr & 13'h003F, 8'(lfsr >> 2), i[0]);
        end
        repeat (3) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule